// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a synthesizable behavioural model of the command front end of a byte-wide flash die. A processor-style bus (active-low chip enable, write enable and output enable, a 17-bit address and an 8-bit data input) is sampled on the system clock. A write cycle is recognised when both strobes have been low together and are then both high again. The decoder walks through the magic address/data pairs that unlock the die. It then accepts a byte program, a single-sector erase or a whole-array erase.

Once a command is accepted, a cycle-count timer stands in for the internal program or erase algorithm. While the timer runs, the block ignores further writes and answers reads with data-polling status: bit 7 is the complement of the value being written, and the other bits read as zero. When the timer expires, the array update is applied and reads return the stored bytes again. The array is a small register store: 8 sectors, selected by the top three address bits, of `2**OFFS_W` bytes each, indexed by the low address bits.

States: `ST_READ` (idle, array reads), `ST_UNLK_A` (first unlock byte seen), `ST_UNLK_B` (unlock pair complete, waiting for a command), `ST_PRG_WAIT` (program command seen, waiting for the target address and data), `ST_ERS_ARM` (erase setup seen), `ST_ERS_UNLK_A` and `ST_ERS_UNLK_B` (second unlock pair), `ST_BUSY_PRG` and `ST_BUSY_ERS` (timer running). Transitions: a matching write advances one state along the sequence. A non-matching write in any unlock or command state returns to `ST_READ`. The write in `ST_PRG_WAIT` enters `ST_BUSY_PRG`. A chip or sector erase command in `ST_ERS_UNLK_B` enters `ST_BUSY_ERS`. Timer expiry in a busy state returns to `ST_READ`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every array byte reads FFH, the decoder is idle, and `dq_out` and `dq_oe` are 0.
- R2: A read is active when `ce_n`=0, `oe_n`=0 and `we_n`=1. One clock after a read is sampled, `dq_oe`=1 and `dq_out` holds the addressed value. When no read is active, `dq_oe`=0 and `dq_out`=00H.
- R3: A write is taken at the first clock at which both `ce_n` and `we_n` are high after both were low together. Address and data are captured at that clock, so the later of the two rising strobes decides the captured values.
- R4: Byte program is AAH@05555H, 55H@02AAAH, A0H@05555H, then data D at target address A. After completion the byte at A becomes old AND D.
- R5: While a program runs, every read returns bit 7 = NOT D[7] and bits 6..0 = 0.
- R6: A program stays busy for PROG_CYC clocks after its last write. After that, reads return the true stored byte.
- R7: Sector erase is AAH@05555H, 55H@02AAAH, 80H@05555H, AAH@05555H, 55H@02AAAH, then 30H at any address in the sector. After SERASE_CYC clocks every byte of that sector reads FFH, and other sectors are unchanged.
- R8: Chip erase is the same sequence, except that the sixth write is 10H@05555H. After CERASE_CYC clocks every byte reads FFH.
- R9: During an erase, a read of a byte being erased returns 00H. During a sector erase, a read of any other sector returns its stored data.
- R10: A write whose address or data does not match the next expected step returns the decoder to idle. The following writes are then treated as the start of a new sequence.
- R11: Writes that arrive while a program or erase is busy are ignored and change neither the state nor the array.
- R12: Address bits 16..14 select the sector and the low OFFS_W bits select the byte. The address bits in between are ignored for array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Registered read data or polling status |
| dq_oe | output | 1 | High when `dq_out` carries a read result |

## Verification
The assertions assume that address and data stay stable from the moment both strobes go low until the clock after both are high again. They also assume that `oe_n` is never low during a write cycle, so that read and write activity do not overlap. The stimulus tasks hold `addr` and `dq_in` across the whole write cycle and keep `oe_n` high while writing. In the one case where the strobes rise at different clocks, the data changes only while the earlier strobe is already high, so the captured value is still well defined.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] MAGIC_ADDR_1 = 17'h05555;
    localparam logic [ADDR_W-1:0] MAGIC_ADDR_2 = 17'h02AAA;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [DATA_W-1:0] OP_SECTOR  = 8'h30;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK_A,
        ST_UNLK_B,
        ST_PRG_WAIT,
        ST_ERS_ARM,
        ST_ERS_UNLK_A,
        ST_ERS_UNLK_B,
        ST_BUSY_PRG,
        ST_BUSY_ERS
    } fsm_state_e;

endpackage

// File: rtl/flash_wr_detect.sv
module flash_wr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_pulse
);

    logic armed;
    logic both_low;
    logic both_high;

    assign both_low  = !ce_n && !we_n;
    assign both_high = ce_n && we_n;
    assign wr_pulse  = armed && both_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (both_low) begin
            armed <= 1'b1;
        end else if (wr_pulse) begin
            armed <= 1'b0;
        end
    end

    // R3: a write cycle yields exactly one capture strobe
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC   = 24,
    parameter int SERASE_CYC = 40,
    parameter int CERASE_CYC = 64,
    parameter int SECT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy_prg,
    output logic              busy_ers,
    output logic              commit_prg,
    output logic              commit_ers,
    output logic              ers_chip,
    output logic [SECT_W-1:0] ers_sect,
    output logic [ADDR_W-1:0] prg_addr,
    output logic [DATA_W-1:0] prg_data
);

    localparam int MAX_A   = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
    localparam int MAX_CYC = (MAX_A > CERASE_CYC) ? MAX_A : CERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fsm_state_e       state;
    fsm_state_e       nxt;
    logic [CNT_W-1:0] cnt;
    logic             hit_m1;
    logic             hit_m2;
    logic             start_prg;
    logic             start_chip;
    logic             start_sect;

    assign hit_m1     = (wr_addr == MAGIC_ADDR_1);
    assign hit_m2     = (wr_addr == MAGIC_ADDR_2);
    assign start_prg  = (state == ST_PRG_WAIT) && wr_pulse;
    assign start_chip = (state == ST_ERS_UNLK_B) && wr_pulse && hit_m1 && (wr_data == OP_CHIP);
    assign start_sect = (state == ST_ERS_UNLK_B) && wr_pulse && (wr_data == OP_SECTOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ: begin
                if (wr_pulse) nxt = (hit_m1 && wr_data == KEY_FIRST) ? ST_UNLK_A : ST_READ;
            end
            ST_UNLK_A: begin
                if (wr_pulse) nxt = (hit_m2 && wr_data == KEY_SECOND) ? ST_UNLK_B : ST_READ;
            end
            ST_UNLK_B: begin
                if (wr_pulse) begin
                    if (hit_m1 && wr_data == OP_PROGRAM)    nxt = ST_PRG_WAIT;
                    else if (hit_m1 && wr_data == OP_ERASE) nxt = ST_ERS_ARM;
                    else                                    nxt = ST_READ;
                end
            end
            ST_PRG_WAIT: begin
                if (start_prg) nxt = ST_BUSY_PRG;
            end
            ST_ERS_ARM: begin
                if (wr_pulse) nxt = (hit_m1 && wr_data == KEY_FIRST) ? ST_ERS_UNLK_A : ST_READ;
            end
            ST_ERS_UNLK_A: begin
                if (wr_pulse) nxt = (hit_m2 && wr_data == KEY_SECOND) ? ST_ERS_UNLK_B : ST_READ;
            end
            ST_ERS_UNLK_B: begin
                if (wr_pulse) nxt = (start_chip || start_sect) ? ST_BUSY_ERS : ST_READ;
            end
            ST_BUSY_PRG, ST_BUSY_ERS: begin
                if (cnt == '0) nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            ers_chip <= 1'b0;
            ers_sect <= '0;
            prg_addr <= '0;
            prg_data <= '0;
        end else if (start_prg) begin
            cnt      <= CNT_W'(PROG_CYC - 1);
            prg_addr <= wr_addr;
            prg_data <= wr_data;
        end else if (start_chip) begin
            cnt      <= CNT_W'(CERASE_CYC - 1);
            ers_chip <= 1'b1;
        end else if (start_sect) begin
            cnt      <= CNT_W'(SERASE_CYC - 1);
            ers_chip <= 1'b0;
            ers_sect <= wr_addr[ADDR_W-1 -: SECT_W];
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        busy_prg   = (state == ST_BUSY_PRG);
        busy_ers   = (state == ST_BUSY_ERS);
        commit_prg = busy_prg && (cnt == '0);
        commit_ers = busy_ers && (cnt == '0);
    end

    // R11: a running operation keeps its state until the timer expires
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BUSY_PRG || state == ST_BUSY_ERS) && cnt != '0) |=> state == $past(state));

    // R4: program can only begin from the data-wait step with a write
    assert_prg_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BUSY_PRG) |-> $past(state == ST_PRG_WAIT && wr_pulse));

    // R7: erase can only begin after the second unlock pair
    assert_ers_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BUSY_ERS) |-> $past(state == ST_ERS_UNLK_B));

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int SECT_W = 3,
    parameter int OFFS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [DATA_W-1:0] rd_byte,
    input  logic              prg_we,
    input  logic [SECT_W-1:0] prg_sect,
    input  logic [OFFS_W-1:0] prg_offs,
    input  logic [DATA_W-1:0] prg_byte,
    input  logic              ers_we,
    input  logic              ers_chip,
    input  logic [SECT_W-1:0] ers_sect
);

    localparam int NSECT = 1 << SECT_W;
    localparam int NBYTE = 1 << OFFS_W;

    logic [DATA_W-1:0] sect_rd [NSECT];

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        logic [DATA_W-1:0] cells [NBYTE];
        logic              hit_prg;
        logic              hit_ers;

        assign hit_prg = prg_we && (prg_sect == SECT_W'(s));
        assign hit_ers = ers_we && (ers_chip || ers_sect == SECT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NBYTE; i++) cells[i] <= '1;
            end else if (hit_ers) begin
                for (int i = 0; i < NBYTE; i++) cells[i] <= '1;
            end else if (hit_prg) begin
                cells[prg_offs] <= cells[prg_offs] & prg_byte;
            end
        end

        assign sect_rd[s] = cells[rd_offs];

        // R4: programming never raises a bit that the written byte had low
        assert_and_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit_prg |=> (cells[$past(prg_offs)] & ~$past(prg_byte)) == '0);
    end

    assign rd_byte = sect_rd[rd_sect];

    // R7: program and erase updates never coincide
    assert_one_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_we && ers_we));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC   = 24,
    parameter int SERASE_CYC = 40,
    parameter int CERASE_CYC = 64,
    parameter int OFFS_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int SECT_W = 3;

    logic              wr_pulse;
    logic              busy_prg;
    logic              busy_ers;
    logic              commit_prg;
    logic              commit_ers;
    logic              ers_chip;
    logic [SECT_W-1:0] ers_sect;
    logic [ADDR_W-1:0] prg_addr;
    logic [DATA_W-1:0] prg_data;
    logic [DATA_W-1:0] arr_byte;
    logic [SECT_W-1:0] rd_sect;
    logic              rd_act;
    logic              ers_hit;
    logic [DATA_W-1:0] rd_val;

    flash_wr_detect u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .wr_pulse (wr_pulse)
    );

    flash_cmd_fsm #(
        .PROG_CYC   (PROG_CYC),
        .SERASE_CYC (SERASE_CYC),
        .CERASE_CYC (CERASE_CYC),
        .SECT_W     (SECT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pulse   (wr_pulse),
        .wr_addr    (addr),
        .wr_data    (dq_in),
        .busy_prg   (busy_prg),
        .busy_ers   (busy_ers),
        .commit_prg (commit_prg),
        .commit_ers (commit_ers),
        .ers_chip   (ers_chip),
        .ers_sect   (ers_sect),
        .prg_addr   (prg_addr),
        .prg_data   (prg_data)
    );

    flash_cell_array #(
        .SECT_W (SECT_W),
        .OFFS_W (OFFS_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sect  (rd_sect),
        .rd_offs  (addr[OFFS_W-1:0]),
        .rd_byte  (arr_byte),
        .prg_we   (commit_prg),
        .prg_sect (prg_addr[ADDR_W-1 -: SECT_W]),
        .prg_offs (prg_addr[OFFS_W-1:0]),
        .prg_byte (prg_data),
        .ers_we   (commit_ers),
        .ers_chip (ers_chip),
        .ers_sect (ers_sect)
    );

    assign rd_sect = addr[ADDR_W-1 -: SECT_W];
    assign rd_act  = !ce_n && !oe_n && we_n;
    assign ers_hit = busy_ers && (ers_chip || ers_sect == rd_sect);

    always_comb begin
        if (busy_prg) begin
            rd_val = {~prg_data[DATA_W-1], {(DATA_W-1){1'b0}}};
        end else if (ers_hit) begin
            rd_val = '0;
        end else begin
            rd_val = arr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            dq_out <= rd_act ? rd_val : '0;
            dq_oe  <= rd_act;
        end
    end

    // R2: an idle output carries no data
    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == '0);

    // R5: polling reads during program expose only bit 7
    assert_poll_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_prg && rd_act) |=> dq_out[DATA_W-2:0] == '0);

    // R9: reads of an erase target show bit 7 low
    assert_ers_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_hit && rd_act) |=> !dq_out[DATA_W-1]);

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int PROG_CYC   = 24;
    localparam int SERASE_CYC = 40;
    localparam int CERASE_CYC = 64;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int checks = 0;
    int failures = 0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    flash_cmd_decoder #(
        .PROG_CYC   (PROG_CYC),
        .SERASE_CYC (SERASE_CYC),
        .CERASE_CYC (CERASE_CYC),
        .OFFS_W     (3)
    ) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    function automatic logic [16:0] loc(input int sect, input int offs);
        return 17'((sect << 14) | offs);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against queued expectations
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(dq_oe === 1'b1 && dq_out === it.exp, it.tag, dq_out, it.exp);
        end
    end

    task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic program_byte(input logic [16:0] a, input logic [7:0] d);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(a, d);
    endtask

    task automatic erase_prefix();
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
    endtask

    initial begin
        wait_cyc(150000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        check(dq_out == 8'h00 && dq_oe == 1'b0, "R1 outputs in reset", dq_out, 8'h00);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: erased array after reset
        for (int s = 0; s < 8; s += 3) bus_read(loc(s, s), 8'hFF, "R1 erased after reset");

        // R2: output quiet when no read is active
        wait_cyc(2);
        @(negedge clk);
        check(dq_out == 8'h00 && dq_oe == 1'b0, "R2 idle output", dq_out, 8'h00);

        // R4 R5 R6: program with polling and timing
        program_byte(loc(3, 2), 8'h5A);
        bus_read(loc(3, 2), 8'h80, "R5 polling right after program");
        wait_cyc(PROG_CYC - 8);
        bus_read(loc(0, 0), 8'h80, "R6 still busy near end");
        wait_cyc(PROG_CYC);
        bus_read(loc(3, 2), 8'h5A, "R6 true data after completion");

        // R4: AND of old and new
        program_byte(loc(3, 2), 8'hF0);
        wait_cyc(PROG_CYC + 4);
        bus_read(loc(3, 2), 8'h50, "R4 program ANDs old byte");

        // R3: we_n rises first, data changes, then ce_n rises
        @(negedge clk);
        addr = 17'h05555; dq_in = 8'h00; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; dq_in = 8'hAA;
        @(negedge clk);
        ce_n = 1'b1;
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(loc(4, 1), 8'h3C);
        bus_read(loc(4, 1), 8'h80, "R3 capture on later strobe");
        wait_cyc(PROG_CYC + 4);
        bus_read(loc(4, 1), 8'h3C, "R3 programmed via later strobe");

        // R12: middle address bits ignored
        bus_read(loc(4, 1) | 17'h00100, 8'h3C, "R12 alias within sector");
        bus_read(loc(4, 9), 8'h3C, "R12 offset wraps on low bits");

        // R10: wrong command value aborts
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h90);
        bus_write(17'h05555, 8'hA0);
        bus_write(loc(6, 0), 8'h00);
        bus_read(loc(6, 0), 8'hFF, "R10 bad command aborts");
        // R10: wrong address aborts
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h01234, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(loc(6, 1), 8'h00);
        bus_read(loc(6, 1), 8'hFF, "R10 bad address aborts");
        program_byte(loc(6, 0), 8'h77);
        wait_cyc(PROG_CYC + 4);
        bus_read(loc(6, 0), 8'h77, "R10 recovery after abort");

        // R11: writes during busy ignored
        program_byte(loc(7, 0), 8'h81);
        program_byte(loc(7, 3), 8'h00);
        bus_read(loc(7, 3), 8'h00, "R11 still polling first op");
        wait_cyc(PROG_CYC + 4);
        bus_read(loc(7, 0), 8'h81, "R11 first program done");
        bus_read(loc(7, 3), 8'hFF, "R11 busy-time program ignored");

        // R7 R9: sector erase
        program_byte(loc(2, 0), 8'h12);
        wait_cyc(PROG_CYC + 4);
        program_byte(loc(5, 0), 8'h34);
        wait_cyc(PROG_CYC + 4);
        erase_prefix();
        bus_write(loc(2, 5), 8'h30);
        bus_read(loc(2, 0), 8'h00, "R9 erase target polls zero");
        bus_read(loc(5, 0), 8'h34, "R9 other sector readable");
        wait_cyc(SERASE_CYC + 4);
        bus_read(loc(2, 0), 8'hFF, "R7 sector erased");
        bus_read(loc(5, 0), 8'h34, "R7 other sector kept");
        bus_read(loc(3, 2), 8'h50, "R7 third sector kept");

        // R8: chip erase
        erase_prefix();
        bus_write(17'h05555, 8'h10);
        bus_read(loc(6, 0), 8'h00, "R9 chip erase polls zero");
        wait_cyc(CERASE_CYC + 4);
        bus_read(loc(5, 0), 8'hFF, "R8 chip erased s5");
        bus_read(loc(3, 2), 8'hFF, "R8 chip erased s3");
        bus_read(loc(7, 0), 8'hFF, "R8 chip erased s7");

        wait_cyc(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule